// File: doc/BRIEF.md
# UART Flow-Control Unit

This block sits between a UART's bit-level serializer/deserializer and the byte queues that feed and drain it. It applies one of three handshake schemes, chosen by a two-bit mode input. In software mode it watches how full the receive queue is and inserts stop and go characters into the outgoing stream. In the same mode it removes those characters from the incoming stream and uses them to pause or resume its own transmission. In the two hardware modes one serial pin is given a new job: the transmit pin becomes a ready-to-receive output, or the receive pin becomes a clear-to-send input.

The receive queue reports its occupancy on `rq_count`. The transmit queue presents its head byte with an empty flag, and the block pops it when it hands the byte to the serializer. Stop and go decisions are registered, so they act one clock after the occupancy that causes them. The byte routing to the queues and the serializer is combinational.

Top module: `uart_flow_gate`

## Requirements
- R1: With `fc_mode` = 0 (no handshake), every received byte is written to the receive queue unchanged. A queued byte is loaded whenever the serializer is ready. `tx_pin` follows `ser_txd` and `ser_rxd` follows `rx_pin`.
- R2: With `fc_mode` = 1 (software handshake), received bytes 0x11 (go) and 0x13 (stop) are not written to the receive queue. All other byte values are written.
- R3: In software mode, a received 0x13 stops the loading of queued data from the next clock on. A received 0x11 allows it again. After reset, loading is allowed.
- R4: In software mode, when the receive queue occupancy reaches 2, a 0x13 is sent exactly once, at the first cycle the serializer is ready.
- R5: In software mode, after a pause, the occupancy falling to 1 causes a 0x11 to be sent at the first cycle the serializer is ready.
- R6: A pending control character is loaded ahead of queued data, and the queue is not popped in that cycle. Only one control character is pending at a time, and a newer one replaces an unsent older one.
- R7: With `fc_mode` = 2 (hardware receive handshake), `tx_pin` is driven low (asserted) until the occupancy reaches 5. It is high from the next clock. It returns low the clock after the occupancy is 1.
- R8: In mode 2 no byte is ever loaded into the serializer. Received bytes, including 0x11 and 0x13, are written to the queue as data.
- R9: With `fc_mode` = 3 (hardware transmit handshake), received bytes are discarded and `ser_rxd` is held high. Queued data is loaded only while `rx_pin` reads low.
- R10: Outside software mode no control character is ever generated or stripped. In mode 0 the occupancy has no effect on `tx_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_mode | input | 2 | 0 none, 1 software, 2 hardware receive handshake, 3 hardware transmit handshake |
| rx_valid | input | 1 | Deserializer presents a byte this cycle |
| rx_data | input | 8 | Received byte |
| rq_wr_en | output | 1 | Write strobe to receive queue |
| rq_wr_data | output | 8 | Byte written to receive queue |
| rq_count | input | CW | Receive queue occupancy |
| tq_empty | input | 1 | Transmit queue empty |
| tq_data | input | 8 | Head byte of transmit queue |
| tq_pop | output | 1 | Pop transmit queue |
| ser_ready | input | 1 | Serializer idle, can accept a byte |
| ser_load | output | 1 | Load byte into serializer |
| ser_data | output | 8 | Byte for serializer |
| ser_txd | input | 1 | Serial line level from serializer |
| tx_pin | output | 1 | Transmit pin (handshake output in mode 2) |
| rx_pin | input | 1 | Receive pin (handshake input in mode 3) |
| ser_rxd | output | 1 | Serial line level to deserializer |

## Verification
The assertions assume that the receive queue occupancy moves by at most one entry per clock. They also assume that `fc_mode` is changed only while no pause is in force. With those assumptions, a rise of the hardware handshake output and the end of a pause can each be tied to a single occupancy value one cycle earlier. The stimulus steps `rq_count` by one per clock and changes mode only after each pause has been released. Byte classification is swept over all 256 values in both the plain and the software mode.

// File: rtl/uart_flow_gate.sv
`timescale 1ns/1ps
module uart_flow_gate #(
  parameter int DEPTH = 8,
  parameter int SW_PAUSE = 2,
  parameter int HW_PAUSE = 5,
  parameter int RESUME_LVL = 1,
  parameter logic [7:0] CH_GO = 8'h11,
  parameter logic [7:0] CH_STOP = 8'h13,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fc_mode,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rq_wr_en,
  output logic [7:0]    rq_wr_data,
  input  logic [CW-1:0] rq_count,
  input  logic          tq_empty,
  input  logic [7:0]    tq_data,
  output logic          tq_pop,
  input  logic          ser_ready,
  output logic          ser_load,
  output logic [7:0]    ser_data,
  input  logic          ser_txd,
  output logic          tx_pin,
  input  logic          rx_pin,
  output logic          ser_rxd
);
  localparam logic [CW-1:0] SW_LVL = CW'(SW_PAUSE);
  localparam logic [CW-1:0] HW_LVL = CW'(HW_PAUSE);
  localparam logic [CW-1:0] GO_LVL = CW'(RESUME_LVL);

  logic sw_m, rts_m, cts_m, flow_m;
  logic rx_hold, ctl_pend, ctl_go, remote_go;
  logic is_ctl, pause_now, resume_now, tx_ok, send_ctl, send_data;
  logic [CW-1:0] pause_lvl;

  assign sw_m   = (fc_mode == 2'd1);
  assign rts_m  = (fc_mode == 2'd2);
  assign cts_m  = (fc_mode == 2'd3);
  assign flow_m = sw_m | rts_m;

  assign is_ctl     = (rx_data == CH_GO) || (rx_data == CH_STOP);
  assign rq_wr_en   = rx_valid && !cts_m && !(sw_m && is_ctl);
  assign rq_wr_data = rx_data;

  assign pause_lvl  = sw_m ? SW_LVL : HW_LVL;
  assign pause_now  = flow_m && !rx_hold && (rq_count == pause_lvl);
  assign resume_now = flow_m && rx_hold && (rq_count == GO_LVL);

  assign tx_ok     = !rts_m && (sw_m ? remote_go : (cts_m ? !rx_pin : 1'b1));
  assign send_ctl  = ser_ready && ctl_pend && sw_m;
  assign send_data = ser_ready && !send_ctl && !tq_empty && tx_ok;
  assign ser_load  = send_ctl | send_data;
  assign ser_data  = send_ctl ? (ctl_go ? CH_GO : CH_STOP) : tq_data;
  assign tq_pop    = send_data;

  assign tx_pin  = rts_m ? rx_hold : ser_txd;
  assign ser_rxd = cts_m ? 1'b1 : rx_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_hold <= 1'b0;
    else if (!flow_m) rx_hold <= 1'b0;
    else if (pause_now) rx_hold <= 1'b1;
    else if (resume_now) rx_hold <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_pend <= 1'b0;
      ctl_go   <= 1'b0;
    end else if (!sw_m) begin
      ctl_pend <= 1'b0;
    end else begin
      if (send_ctl) ctl_pend <= 1'b0;
      if (pause_now) begin
        ctl_pend <= 1'b1;
        ctl_go   <= 1'b0;
      end else if (resume_now) begin
        ctl_pend <= 1'b1;
        ctl_go   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remote_go <= 1'b1;
    else if (!sw_m) remote_go <= 1'b1;
    else if (rx_valid && rx_data == CH_GO) remote_go <= 1'b1;
    else if (rx_valid && rx_data == CH_STOP) remote_go <= 1'b0;
  end

  assert_strip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_m && rq_wr_en) |-> (rq_wr_data != CH_GO && rq_wr_data != CH_STOP));
  assert_ctl_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_m && ctl_pend && ser_ready) |-> (ser_load && !tq_pop));
  assert_rts_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_m && $past(rts_m) && $rose(tx_pin)) |-> ($past(rq_count) == HW_LVL));
  assert_resume_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_m && $past(flow_m) && $fell(rx_hold)) |-> ($past(rq_count) == GO_LVL));
  assert_rts_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rts_m |-> !ser_load);
  assert_cts_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_m && tq_pop) |-> !rx_pin);
  assert_cts_no_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cts_m |-> !rq_wr_en);
  assert_pop_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tq_pop |-> (ser_load && !tq_empty));
endmodule

// File: tb/uart_flow_gate_tb.sv
`timescale 1ns/1ps
module uart_flow_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fc_mode = 2'd0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rq_wr_en;
  logic [7:0] rq_wr_data;
  logic [3:0] rq_count = 4'd0;
  logic tq_empty = 1'b1;
  logic [7:0] tq_data = 8'h00;
  logic tq_pop;
  logic ser_ready = 1'b0;
  logic ser_load;
  logic [7:0] ser_data;
  logic ser_txd = 1'b1;
  logic tx_pin;
  logic rx_pin = 1'b1;
  logic ser_rxd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_flow_gate u_dut (
    .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rq_wr_en(rq_wr_en), .rq_wr_data(rq_wr_data), .rq_count(rq_count),
    .tq_empty(tq_empty), .tq_data(tq_data), .tq_pop(tq_pop),
    .ser_ready(ser_ready), .ser_load(ser_load), .ser_data(ser_data),
    .ser_txd(ser_txd), .tx_pin(tx_pin), .rx_pin(rx_pin), .ser_rxd(ser_rxd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset wr_en", rq_wr_en, 0);
    chk("R1 reset load", ser_load, 0);
    chk("R1 reset tx_pin", tx_pin, 1);
    chk("R1 reset ser_rxd", ser_rxd, 1);

    // R1: plain mode passes every byte
    for (int b = 0; b < 256; b++) begin
      rx_valid = 1'b1; rx_data = 8'(b); settle();
      chk("R1 pass wr_en", rq_wr_en, 1);
      chk("R1 pass data", rq_wr_data, 32'(b));
    end
    rx_valid = 1'b0;
    tq_empty = 1'b0; tq_data = 8'h5A; ser_ready = 1'b1; ser_txd = 1'b0; rx_pin = 1'b0; settle();
    chk("R1 load", ser_load, 1);
    chk("R1 data", ser_data, 32'h5A);
    chk("R1 pop", tq_pop, 1);
    chk("R1 tx_pin follows", tx_pin, 0);
    chk("R1 rx follows", ser_rxd, 0);
    // R10: occupancy ignored in plain mode
    ser_txd = 1'b1; rx_pin = 1'b1;
    for (int c = 0; c <= 8; c++) begin
      rq_count = 4'(c); step();
      chk("R10 plain tx_pin", tx_pin, 1);
      chk("R10 plain load", ser_load, 1);
      chk("R10 plain data", ser_data, 32'h5A);
    end
    rq_count = 4'd0; ser_ready = 1'b0; step();

    // R2: software mode strips 0x11 and 0x13
    fc_mode = 2'd1; step();
    for (int b = 0; b < 256; b++) begin
      rx_valid = 1'b1; rx_data = 8'(b); settle();
      chk("R2 strip", rq_wr_en, (b == 8'h11 || b == 8'h13) ? 0 : 1);
    end
    rx_valid = 1'b0; settle();

    // R3: remote stop/go
    ser_ready = 1'b1; tq_data = 8'hA7; settle();
    chk("R3 default go", ser_load, 1);
    rx_valid = 1'b1; rx_data = 8'h13; step();
    rx_valid = 1'b0; settle();
    chk("R3 stopped load", ser_load, 0);
    chk("R3 stopped pop", tq_pop, 0);
    rx_valid = 1'b1; rx_data = 8'h11; step();
    rx_valid = 1'b0; settle();
    chk("R3 resumed load", ser_load, 1);
    chk("R3 resumed data", ser_data, 32'hA7);

    // R4 / R6: pause at 2 sends stop ahead of data
    ser_ready = 1'b0; rq_count = 4'd1; step();
    rq_count = 4'd2; step();
    chk("R4 wait ready", ser_load, 0);
    ser_ready = 1'b1; settle();
    chk("R4 stop load", ser_load, 1);
    chk("R4 stop char", ser_data, 32'h13);
    chk("R6 no pop with ctl", tq_pop, 0);
    step();
    chk("R6 data after ctl", ser_data, 32'hA7);
    chk("R6 pop after ctl", tq_pop, 1);
    step();
    chk("R4 stop sent once", ser_data, 32'hA7);

    // R5: resume at 1
    ser_ready = 1'b0;
    rq_count = 4'd3; step();
    rq_count = 4'd2; step();
    chk("R5 no early go", ser_load, 0);
    rq_count = 4'd1; step();
    ser_ready = 1'b1; settle();
    chk("R5 go char", ser_data, 32'h11);
    chk("R5 go no pop", tq_pop, 0);
    step();
    chk("R5 data after go", tq_pop, 1);

    // R6: newer control replaces unsent one
    ser_ready = 1'b0;
    rq_count = 4'd2; step();
    rq_count = 4'd1; step();
    ser_ready = 1'b1; settle();
    chk("R6 replaced char", ser_data, 32'h11);
    step();
    chk("R6 single pending", tq_pop, 1);
    chk("R6 single pending data", ser_data, 32'hA7);
    rq_count = 4'd0; step();

    // R7 / R8: hardware receive handshake
    fc_mode = 2'd2; step();
    begin
      automatic logic hold = 1'b0;
      for (int c = 0; c <= 5; c++) begin
        rq_count = 4'(c); settle();
        chk("R7 rise tx_pin", tx_pin, 32'(hold));
        chk("R8 no load", ser_load, 0);
        step();
        if (c == 5) hold = 1'b1;
      end
      for (int c = 4; c >= 1; c--) begin
        rq_count = 4'(c); settle();
        chk("R7 held tx_pin", tx_pin, 32'(hold));
        chk("R8 no load", ser_load, 0);
        step();
        if (c == 1) hold = 1'b0;
      end
      rq_count = 4'd0; settle();
      chk("R7 released tx_pin", tx_pin, 32'(hold));
    end
    rx_valid = 1'b1; rx_data = 8'h13; settle();
    chk("R8 ctl as data", rq_wr_en, 1);
    chk("R10 no strip", rq_wr_data, 32'h13);
    rx_valid = 1'b0; step();

    // R9: hardware transmit handshake
    fc_mode = 2'd3; rx_pin = 1'b1; step();
    rx_valid = 1'b1; rx_data = 8'h41; settle();
    chk("R9 rx discarded", rq_wr_en, 0);
    chk("R9 rxd idle", ser_rxd, 1);
    chk("R9 cts high", ser_load, 0);
    rx_valid = 1'b0; rx_pin = 1'b0; settle();
    chk("R9 cts low load", ser_load, 1);
    chk("R9 cts low pop", tq_pop, 1);
    chk("R9 rxd idle low pin", ser_rxd, 1);
    rq_count = 4'd2; rx_pin = 1'b1; step();
    rq_count = 4'd1; step();
    chk("R10 no ctl in cts", ser_load, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule